// File: doc/BRIEF.md
# MSI Snooping Cache Line Controller

This block keeps the coherence state for every line of a small direct-mapped private cache that sits on a shared snooping bus. A line is invalid, shared or modified. The controller serves load and store requests from the local processor. It puts read, read-for-ownership, upgrade and write-back transactions on the bus. It also watches the transactions that other caches place on the bus, and answers a snooped read by supplying data whenever it holds the only valid copy.

The processor side uses a valid/ready handshake. The processor holds `cpu_valid`, `cpu_write` and `cpu_line` steady until `cpu_ready` is seen. A request that already has permission completes in the same cycle. Any other request is held while the controller wins the bus and the transaction completes, and it then completes as a hit. Addresses are line addresses. The low `INDEX_W` bits select the entry and the remaining bits form the tag. The data array, memory and arbitration between caches sit outside the block. The bus arbiter never grants this cache in a cycle that carries another cache's snoop, and no snoop arrives between grant and done.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset every entry is invalid and `cpu_ready`, `bus_req` and `snp_supply` are low, so the first access to any line goes to the bus.
- R2: A read miss issues bus command READ (`bus_cmd`=0) for `cpu_line`. The entry fills in shared on `bus_done`, and the read then completes in the following cycle.
- R3: A write miss whose victim entry is invalid or shared issues READX (`bus_cmd`=1) with no write-back, and the entry fills in modified.
- R4: A write to a line held in shared issues UPGR (`bus_cmd`=2), and the line becomes modified when the transaction completes.
- R5: A read hit in shared or modified, or a write hit in modified, raises `cpu_ready` in the cycle the request is presented, without any bus request.
- R6: A snooped READ to a line held in shared changes nothing and supplies no data.
- R7: A snooped READX or UPGR to a line held in shared or modified makes it invalid.
- R8: A snooped READ to a line held in modified pulses `snp_supply` one cycle later with `snp_supply_line` equal to the snooped line, and downgrades the line to shared.
- R9: A miss whose victim entry is modified under another tag first issues WB (`bus_cmd`=3) for the victim line and then fetches the new line. A shared victim is dropped without any bus traffic.
- R10: A snoop that changes the state of the line a request targets takes priority. A hit in that cycle does not complete, and a request still waiting for grant is withdrawn and then re-issued with a command chosen from the new state.
- R11: Once `bus_req` rises, `bus_cmd` and `bus_line` hold steady until `bus_done`, and `bus_req` falls in the cycle after `bus_done`.
- R12: A snooped WB has no effect on any line and supplies no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_valid | input | 1 | Processor request present |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_line | input | ADDR_W | Line address of the request |
| cpu_ready | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Controller owns or wants the bus |
| bus_cmd | output | 2 | 0 READ, 1 READX, 2 UPGR, 3 WB |
| bus_line | output | ADDR_W | Line address of the bus transaction |
| bus_grant | input | 1 | One-cycle grant from the arbiter |
| bus_done | input | 1 | One-cycle completion of the granted transaction |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_line | input | ADDR_W | Snooped line address |
| snp_supply | output | 1 | This cache supplies the data for a snooped read |
| snp_supply_line | output | ADDR_W | Line being supplied |

## Verification
The bench targets the snoop-versus-request collisions. It sends an invalidating snoop in the same cycle as a shared read hit, and it sends one while an upgrade is still waiting for grant. A design that let the local request win would complete a stale read, or it would be granted an upgrade for a line it no longer holds. The bench evicts a modified line with a conflicting read, where a missing write-back would lose the only valid copy. It also evicts a shared victim, where a needless write-back would waste bus time. It sends snooped reads to both shared and modified lines and a snooped write-back. These catch a design that supplies data from a shared copy, forgets to downgrade after supplying, or reacts to a write-back.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        LINE_I = 2'd0,
        LINE_S = 2'd1,
        LINE_M = 2'd2
    } line_state_t;

    typedef enum logic [1:0] {
        BUS_READ  = 2'd0,
        BUS_READX = 2'd1,
        BUS_UPGR  = 2'd2,
        BUS_WB    = 2'd3
    } bus_cmd_t;

    typedef enum logic [2:0] {
        FSM_IDLE,
        FSM_WB_REQ,
        FSM_WB_WAIT,
        FSM_FETCH_REQ,
        FSM_FETCH_WAIT
    } fsm_state_t;

endpackage

// File: rtl/msi_tag_array.sv
module msi_tag_array
    import msi_pkg::*;
#(
    parameter int INDEX_W = 3,
    parameter int TAG_W   = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] cpu_idx,
    output logic [TAG_W-1:0]   cpu_tag,
    output line_state_t        cpu_state,
    input  logic [INDEX_W-1:0] snp_idx,
    output logic [TAG_W-1:0]   snp_tag,
    output line_state_t        snp_state,
    input  logic               upd_en,
    input  logic [INDEX_W-1:0] upd_idx,
    input  line_state_t        upd_state,
    input  logic               fill_en,
    input  logic [INDEX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0]   fill_tag,
    input  line_state_t        fill_state
);

    localparam int LINES = 1 << INDEX_W;

    line_state_t      st_all  [LINES];
    logic [TAG_W-1:0] tag_all [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_entry
        line_state_t      st_r;
        logic [TAG_W-1:0] tag_r;

        // A fill belongs to this cache's own, later-ordered transaction,
        // so it overrides a snoop update landing on the same entry.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_r  <= LINE_I;
                tag_r <= '0;
            end else if (fill_en && fill_idx == INDEX_W'(g)) begin
                st_r  <= fill_state;
                tag_r <= fill_tag;
            end else if (upd_en && upd_idx == INDEX_W'(g)) begin
                st_r  <= upd_state;
            end
        end

        assign st_all[g]  = st_r;
        assign tag_all[g] = tag_r;
    end

    assign cpu_tag   = tag_all[cpu_idx];
    assign cpu_state = st_all[cpu_idx];
    assign snp_tag   = tag_all[snp_idx];
    assign snp_state = st_all[snp_idx];

endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
    import msi_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int INDEX_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  snp_valid,
    input  logic [1:0]            snp_cmd,
    input  logic [ADDR_W-1:0]     snp_line,
    input  logic [ADDR_W-INDEX_W-1:0] look_tag,
    input  line_state_t           look_state,
    output logic                  upd_en,
    output logic [INDEX_W-1:0]    upd_idx,
    output line_state_t           upd_state,
    output logic                  supply,
    output logic [ADDR_W-1:0]     supply_line
);

    localparam int TAG_W = ADDR_W - INDEX_W;

    logic line_hit;
    logic give_data;

    assign line_hit = snp_valid && (look_state != LINE_I)
                   && (look_tag == snp_line[ADDR_W-1:INDEX_W]);
    assign upd_idx  = snp_line[INDEX_W-1:0];

    always_comb begin
        upd_en    = 1'b0;
        upd_state = look_state;
        give_data = 1'b0;
        if (line_hit) begin
            unique case (bus_cmd_t'(snp_cmd))
                BUS_READ: begin
                    if (look_state == LINE_M) begin
                        upd_en    = 1'b1;
                        upd_state = LINE_S;
                        give_data = 1'b1;
                    end
                end
                BUS_READX, BUS_UPGR: begin
                    upd_en    = 1'b1;
                    upd_state = LINE_I;
                end
                BUS_WB: begin
                    upd_en = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            supply      <= 1'b0;
            supply_line <= '0;
        end else begin
            supply      <= give_data;
            supply_line <= snp_line;
        end
    end

    logic unused_tag_w;
    assign unused_tag_w = (TAG_W == 0);

endmodule

// File: rtl/msi_ctrl_fsm.sv
module msi_ctrl_fsm
    import msi_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int INDEX_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cpu_valid,
    input  logic                      cpu_write,
    input  logic [ADDR_W-1:0]         cpu_line,
    output logic                      cpu_ready,
    input  logic [ADDR_W-INDEX_W-1:0] cpu_tag_rd,
    input  line_state_t               cpu_state_rd,
    input  logic                      upd_en,
    input  logic [INDEX_W-1:0]        upd_idx,
    output logic                      bus_req,
    output logic [1:0]                bus_cmd,
    output logic [ADDR_W-1:0]         bus_line,
    input  logic                      bus_grant,
    input  logic                      bus_done,
    output logic                      fill_en,
    output logic [INDEX_W-1:0]        fill_idx,
    output logic [ADDR_W-INDEX_W-1:0] fill_tag,
    output line_state_t               fill_state
);

    fsm_state_t        state_q, state_d;
    logic [ADDR_W-1:0] line_q, line_d;
    bus_cmd_t          cmd_q, cmd_d;

    logic [INDEX_W-1:0]        cpu_idx;
    logic [ADDR_W-INDEX_W-1:0] cpu_tag;
    logic cpu_hit, cpu_perm, cpu_clash, held_clash;

    assign cpu_idx    = cpu_line[INDEX_W-1:0];
    assign cpu_tag    = cpu_line[ADDR_W-1:INDEX_W];
    assign cpu_hit    = (cpu_state_rd != LINE_I) && (cpu_tag_rd == cpu_tag);
    assign cpu_perm   = cpu_hit && (!cpu_write || cpu_state_rd == LINE_M);
    assign cpu_clash  = upd_en && (upd_idx == cpu_idx);
    assign held_clash = upd_en && (upd_idx == line_q[INDEX_W-1:0]);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FSM_IDLE;
            line_q  <= '0;
            cmd_q   <= BUS_READ;
        end else begin
            state_q <= state_d;
            line_q  <= line_d;
            cmd_q   <= cmd_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        line_d  = line_q;
        cmd_d   = cmd_q;
        unique case (state_q)
            FSM_IDLE: begin
                if (cpu_valid && !cpu_clash && !cpu_perm) begin
                    if (!cpu_hit && cpu_state_rd == LINE_M) begin
                        state_d = FSM_WB_REQ;
                        line_d  = {cpu_tag_rd, cpu_idx};
                    end else begin
                        state_d = FSM_FETCH_REQ;
                        line_d  = cpu_line;
                        if (!cpu_write)
                            cmd_d = BUS_READ;
                        else if (cpu_hit)
                            cmd_d = BUS_UPGR;
                        else
                            cmd_d = BUS_READX;
                    end
                end
            end
            FSM_WB_REQ: begin
                if (held_clash)
                    state_d = FSM_IDLE;
                else if (bus_grant)
                    state_d = FSM_WB_WAIT;
            end
            FSM_WB_WAIT: begin
                if (bus_done)
                    state_d = FSM_IDLE;
            end
            FSM_FETCH_REQ: begin
                if (held_clash)
                    state_d = FSM_IDLE;
                else if (bus_grant)
                    state_d = FSM_FETCH_WAIT;
            end
            FSM_FETCH_WAIT: begin
                if (bus_done)
                    state_d = FSM_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        cpu_ready  = 1'b0;
        bus_req    = 1'b0;
        bus_cmd    = cmd_q;
        bus_line   = line_q;
        fill_en    = 1'b0;
        fill_idx   = line_q[INDEX_W-1:0];
        fill_tag   = line_q[ADDR_W-1:INDEX_W];
        fill_state = LINE_I;
        unique case (state_q)
            FSM_IDLE: begin
                cpu_ready = cpu_valid && cpu_perm && !cpu_clash;
            end
            FSM_WB_REQ: begin
                bus_req = 1'b1;
                bus_cmd = BUS_WB;
            end
            FSM_WB_WAIT: begin
                bus_req    = 1'b1;
                bus_cmd    = BUS_WB;
                fill_en    = bus_done;
                fill_state = LINE_I;
            end
            FSM_FETCH_REQ: begin
                bus_req = 1'b1;
            end
            FSM_FETCH_WAIT: begin
                bus_req    = 1'b1;
                fill_en    = bus_done;
                fill_state = (cmd_q == BUS_READ) ? LINE_S : LINE_M;
            end
        endcase
    end

endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int INDEX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_line,
    output logic              cpu_ready,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_line,
    input  logic              bus_grant,
    input  logic              bus_done,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_line,
    output logic              snp_supply,
    output logic [ADDR_W-1:0] snp_supply_line
);

    localparam int TAG_W = ADDR_W - INDEX_W;

    logic [TAG_W-1:0]   cpu_tag_rd, snp_tag_rd, fill_tag;
    line_state_t        cpu_state_rd, snp_state_rd, upd_state, fill_state;
    logic               upd_en, fill_en;
    logic [INDEX_W-1:0] upd_idx, fill_idx;

    msi_tag_array #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_idx    (cpu_line[INDEX_W-1:0]),
        .cpu_tag    (cpu_tag_rd),
        .cpu_state  (cpu_state_rd),
        .snp_idx    (snp_line[INDEX_W-1:0]),
        .snp_tag    (snp_tag_rd),
        .snp_state  (snp_state_rd),
        .upd_en     (upd_en),
        .upd_idx    (upd_idx),
        .upd_state  (upd_state),
        .fill_en    (fill_en),
        .fill_idx   (fill_idx),
        .fill_tag   (fill_tag),
        .fill_state (fill_state)
    );

    msi_snoop_unit #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W)) u_snoop (
        .clk         (clk),
        .rst_n       (rst_n),
        .snp_valid   (snp_valid),
        .snp_cmd     (snp_cmd),
        .snp_line    (snp_line),
        .look_tag    (snp_tag_rd),
        .look_state  (snp_state_rd),
        .upd_en      (upd_en),
        .upd_idx     (upd_idx),
        .upd_state   (upd_state),
        .supply      (snp_supply),
        .supply_line (snp_supply_line)
    );

    msi_ctrl_fsm #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_valid    (cpu_valid),
        .cpu_write    (cpu_write),
        .cpu_line     (cpu_line),
        .cpu_ready    (cpu_ready),
        .cpu_tag_rd   (cpu_tag_rd),
        .cpu_state_rd (cpu_state_rd),
        .upd_en       (upd_en),
        .upd_idx      (upd_idx),
        .bus_req      (bus_req),
        .bus_cmd      (bus_cmd),
        .bus_line     (bus_line),
        .bus_grant    (bus_grant),
        .bus_done     (bus_done),
        .fill_en      (fill_en),
        .fill_idx     (fill_idx),
        .fill_tag     (fill_tag),
        .fill_state   (fill_state)
    );

endmodule

// File: rtl/msi_line_ctrl_chk.sv
module msi_line_ctrl_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_valid,
    input logic              cpu_ready,
    input logic              bus_req,
    input logic [1:0]        bus_cmd,
    input logic [ADDR_W-1:0] bus_line,
    input logic              bus_done,
    input logic              snp_valid,
    input logic [1:0]        snp_cmd,
    input logic [ADDR_W-1:0] snp_line,
    input logic              snp_supply,
    input logic [ADDR_W-1:0] snp_supply_line
);

    a_r11_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> (!bus_req || ($stable(bus_cmd) && $stable(bus_line))));

    a_r11_release_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_done) |=> !bus_req);

    a_r5_ready_without_bus: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> (cpu_valid && !bus_req));

    a_r8_supply_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> ($past(snp_valid) && $past(snp_cmd) == 2'd0
                        && snp_supply_line == $past(snp_line)));

    a_r12_no_supply_on_other_cmds: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_cmd != 2'd0) |=> !snp_supply);

endmodule

bind msi_line_ctrl msi_line_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cpu_valid       (cpu_valid),
    .cpu_ready       (cpu_ready),
    .bus_req         (bus_req),
    .bus_cmd         (bus_cmd),
    .bus_line        (bus_line),
    .bus_done        (bus_done),
    .snp_valid       (snp_valid),
    .snp_cmd         (snp_cmd),
    .snp_line        (snp_line),
    .snp_supply      (snp_supply),
    .snp_supply_line (snp_supply_line)
);

// File: tb/msi_line_ctrl_test.sv
module msi_line_ctrl_test;

    localparam int AW = 12;
    localparam int NL = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_valid = 1'b0, cpu_write = 1'b0;
    logic [AW-1:0] cpu_line = '0;
    logic cpu_ready;
    logic bus_req;
    logic [1:0] bus_cmd;
    logic [AW-1:0] bus_line;
    logic bus_grant = 1'b0, bus_done = 1'b0;
    logic snp_valid = 1'b0;
    logic [1:0] snp_cmd = 2'd0;
    logic [AW-1:0] snp_line = '0;
    logic snp_supply;
    logic [AW-1:0] snp_supply_line;

    always #4 clk = ~clk;

    msi_line_ctrl #(.ADDR_W(AW), .INDEX_W(3)) uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_line(cpu_line), .cpu_ready(cpu_ready),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_line(bus_line),
        .bus_grant(bus_grant), .bus_done(bus_done),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_line(snp_line),
        .snp_supply(snp_supply), .snp_supply_line(snp_supply_line)
    );

    int checks = 0, fails = 0;
    bit finished = 0;
    int gdelay = 1, ddelay = 2;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int m_st[NL];   // 0 invalid, 1 shared, 2 modified
    int m_tag[NL];
    int m_ph, m_cmd, m_line, m_sup_line;
    bit m_sup;

    function automatic bit snoop_changes(input int si, input int stg);
        return snp_valid && m_st[si] != 0 && m_tag[si] == stg &&
               (snp_cmd == 2'd1 || snp_cmd == 2'd2 || (snp_cmd == 2'd0 && m_st[si] == 2));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_tag[i] = 0; end
            m_ph = 0; m_cmd = 0; m_line = 0; m_sup = 0; m_sup_line = 0;
        end else begin
            int si, stg, ci, ctg, nph, f_st;
            bit chg, hit, perm, f_en;
            si = int'(snp_line) % NL; stg = int'(snp_line) / NL;
            ci = int'(cpu_line) % NL; ctg = int'(cpu_line) / NL;
            chg = snoop_changes(si, stg);
            hit = m_st[ci] != 0 && m_tag[ci] == ctg;
            perm = hit && (!cpu_write || m_st[ci] == 2);
            f_en = 0; f_st = 0; nph = m_ph;
            case (m_ph)
                0: if (cpu_valid && !(chg && si == ci) && !perm) begin
                       if (!hit && m_st[ci] == 2) begin nph = 1; m_line = m_tag[ci] * NL + ci; end
                       else begin nph = 3; m_line = int'(cpu_line); m_cmd = !cpu_write ? 0 : (hit ? 2 : 1); end
                   end
                1, 3: if (chg && si == m_line % NL) nph = 0; else if (bus_grant) nph = m_ph + 1;
                2: if (bus_done) begin f_en = 1; f_st = 0; nph = 0; end
                4: if (bus_done) begin f_en = 1; f_st = (m_cmd == 0) ? 1 : 2; nph = 0; end
                default: nph = 0;
            endcase
            m_sup = chg && snp_cmd == 2'd0;
            m_sup_line = int'(snp_line);
            if (chg) m_st[si] = (snp_cmd == 2'd0) ? 1 : 0;
            if (f_en) begin m_st[m_line % NL] = f_st; m_tag[m_line % NL] = m_line / NL; end
            m_ph = nph;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int si, ci;
            bit chg, perm, e_ready, e_req;
            int e_cmd;
            si = int'(snp_line) % NL; ci = int'(cpu_line) % NL;
            chg = snoop_changes(si, int'(snp_line) / NL);
            perm = m_st[ci] != 0 && m_tag[ci] == int'(cpu_line) / NL && (!cpu_write || m_st[ci] == 2);
            e_ready = m_ph == 0 && cpu_valid && perm && !(chg && si == ci);
            e_req = m_ph != 0;
            e_cmd = (m_ph == 1 || m_ph == 2) ? 3 : m_cmd;
            check(cpu_ready == e_ready, "R5", "cpu_ready vs model", int'(cpu_ready), int'(e_ready));
            check(bus_req == e_req, "R11", "bus_req vs model", int'(bus_req), int'(e_req));
            if (e_req) begin
                check(int'(bus_cmd) == e_cmd, "R11", "bus_cmd vs model", int'(bus_cmd), e_cmd);
                check(int'(bus_line) == m_line, "R11", "bus_line vs model", int'(bus_line), m_line);
            end
            check(snp_supply == m_sup, "R8", "snp_supply vs model", int'(snp_supply), int'(m_sup));
            if (m_sup)
                check(int'(snp_supply_line) == m_sup_line, "R8", "supply line vs model",
                      int'(snp_supply_line), m_sup_line);
        end
    end

    // ---------------- bus agent and monitors ----------------
    int ag = 0, cnt = 0;
    always @(posedge clk) begin
        #1;
        bus_grant = 1'b0; bus_done = 1'b0;
        if (!rst_n) begin ag = 0; cnt = 0; end
        else case (ag)
            0: if (bus_req) begin
                   if (cnt >= gdelay) begin bus_grant = 1'b1; ag = 1; cnt = 0; end
                   else cnt++;
               end else cnt = 0;
            1: if (cnt >= ddelay) begin bus_done = 1'b1; ag = 2; end else cnt++;
            default: begin ag = 0; cnt = 0; end
        endcase
    end

    logic [AW+1:0] tx_q[$];
    int sup_q[$];
    always @(negedge clk) begin
        if (rst_n && bus_req && bus_grant) tx_q.push_back({bus_cmd, bus_line});
        if (rst_n && snp_supply) sup_q.push_back(int'(snp_supply_line));
    end

    task automatic expect_tx(input int cmd, input int line, input string req);
        logic [AW+1:0] e;
        if (tx_q.size() == 0) begin
            check(0, req, "missing bus transaction", -1, cmd);
        end else begin
            e = tx_q.pop_front();
            check(int'(e[AW+1:AW]) == cmd, req, "granted command", int'(e[AW+1:AW]), cmd);
            check(int'(e[AW-1:0]) == line, req, "granted line", int'(e[AW-1:0]), line);
        end
    endtask

    task automatic expect_no_tx(input string req);
        check(tx_q.size() == 0, req, "extra bus transactions", tx_q.size(), 0);
        tx_q.delete();
    endtask

    task automatic cpu_op(input bit w, input logic [AW-1:0] l, output int lat);
        @(posedge clk); #1;
        cpu_valid = 1'b1; cpu_write = w; cpu_line = l; lat = 0;
        forever begin
            @(negedge clk);
            if (cpu_ready) break;
            lat++;
        end
        @(posedge clk); #1;
        cpu_valid = 1'b0;
    endtask

    task automatic snoop(input logic [1:0] c, input logic [AW-1:0] l);
        @(posedge clk); #1;
        snp_valid = 1'b1; snp_cmd = c; snp_line = l;
        @(posedge clk); #1;
        snp_valid = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    localparam logic [AW-1:0] LA = 12'h010;  // index 0, tag 2
    localparam logic [AW-1:0] LB = 12'h018;  // index 0, tag 3
    localparam logic [AW-1:0] LC = 12'h023;  // index 3, tag 4
    localparam logic [AW-1:0] LE = 12'h02B;  // index 3, tag 5

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(0, "R11", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int lat;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(bus_req == 0 && cpu_ready == 0 && snp_supply == 0, "R1", "outputs in reset", 1, 0);
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        check(bus_req == 0 && snp_supply == 0, "R1", "outputs after reset", int'(bus_req), 0);

        // R1 / R2: cold read miss, then read hit
        cpu_op(0, LA, lat);
        check(lat > 0, "R1", "first read latency nonzero", lat, 1);
        expect_tx(0, int'(LA), "R2");
        cpu_op(0, LA, lat);
        check(lat == 0, "R5", "shared read hit latency", lat, 0);
        expect_no_tx("R5");

        // R6: snooped read to shared line
        snoop(2'd0, LA);
        check(sup_q.size() == 0, "R6", "supply from shared", sup_q.size(), 0);
        cpu_op(0, LA, lat);
        check(lat == 0, "R6", "line still shared", lat, 0);
        expect_no_tx("R6");

        // R4: write to shared upgrades, then R5 write hit in modified
        cpu_op(1, LA, lat);
        expect_tx(2, int'(LA), "R4");
        cpu_op(1, LA, lat);
        check(lat == 0, "R5", "modified write hit latency", lat, 0);
        expect_no_tx("R5");

        // R8: snooped read to modified supplies and downgrades
        snoop(2'd0, LA);
        check(sup_q.size() == 1 && sup_q[0] == int'(LA), "R8", "supplied line",
              sup_q.size() > 0 ? sup_q[0] : -1, int'(LA));
        sup_q.delete();
        cpu_op(1, LA, lat);
        expect_tx(2, int'(LA), "R8");

        // R7: snooped READX and UPGR invalidate
        snoop(2'd1, LA);
        check(sup_q.size() == 0, "R7", "no supply on readx", sup_q.size(), 0);
        cpu_op(0, LA, lat);
        expect_tx(0, int'(LA), "R7");
        snoop(2'd2, LA);
        cpu_op(0, LA, lat);
        expect_tx(0, int'(LA), "R7");

        // R9: modified victim written back, shared victim dropped
        cpu_op(1, LA, lat);
        expect_tx(2, int'(LA), "R4");
        cpu_op(0, LB, lat);
        expect_tx(3, int'(LA), "R9");
        expect_tx(0, int'(LB), "R9");
        cpu_op(0, LA, lat);
        expect_tx(0, int'(LA), "R9");
        expect_no_tx("R9");

        // R10: invalidating snoop withdraws a pending upgrade
        gdelay = 3;
        fork
            cpu_op(1, LA, lat);
            begin @(posedge clk); snoop(2'd1, LA); end
        join
        expect_tx(1, int'(LA), "R10");
        expect_no_tx("R10");
        gdelay = 1;

        // R10: same-cycle snoop blocks a shared read hit
        cpu_op(0, LC, lat);
        expect_tx(0, int'(LC), "R2");
        fork
            cpu_op(0, LC, lat);
            snoop(2'd1, LC);
        join
        check(lat > 0, "R10", "hit blocked by snoop", lat, 1);
        expect_tx(0, int'(LC), "R10");

        // R12: snooped write-back ignored
        snoop(2'd3, LA);
        check(sup_q.size() == 0, "R12", "no supply on wb", sup_q.size(), 0);
        cpu_op(1, LA, lat);
        check(lat == 0, "R12", "line kept modified", lat, 0);
        expect_no_tx("R12");

        // R3: write miss over a shared victim
        cpu_op(1, LE, lat);
        expect_tx(1, int'(LE), "R3");
        expect_no_tx("R3");
        cpu_op(1, LE, lat);
        check(lat == 0, "R3", "filled modified", lat, 0);

        repeat (4) @(posedge clk);
        finish_run();
    end

endmodule